// File: doc/BRIEF.md
# Fixed-Point Requantizer with Selectable Rounding and Overflow Handling

This block takes a fixed-point sample in one format and re-expresses it in another. Both formats are fixed when the block is elaborated. A format is described by its total width and its count of integer bits, and the fraction width is the difference of the two. A single parameter sets the formats as signed (two's complement) or unsigned. The block first lines up the binary points of the two formats. It then uses one of seven quantization rules on any fraction bits that are dropped, and one of five overflow rules when the rounded value does not fit the output integer range.

The quantization rule, the overflow rule and the count of forced high bits for plain wrap are run-time inputs, sampled together with each sample. One register stage sits between input and output, and a valid bit travels alongside the data. A flag comes out with each result and is set when the overflow rule had to change the value.

Top module: `fxq_requant`

## Requirements
- R1: The fraction width is total width minus integer width. A value that needs no rounding and fits the output range comes out exactly equal to the input, after the binary points are aligned. The flag is 0 for such a value.
- R2: Quantization code 0 (the default) and the unused code 7 truncate toward minus infinity.
- R3: Codes 1 to 4 round to the nearest output step. An exact half-step tie goes as follows: code 1 toward plus infinity, code 2 toward zero, code 3 toward minus infinity, code 4 away from zero.
- R4: Code 5 rounds to nearest and breaks an exact half-step tie toward the even output value (output LSB 0).
- R5: Code 6 truncates toward zero, so a negative value with non-zero dropped bits moves up by one step.
- R6: Overflow code 0 (the default) and the unused codes 5 to 7 wrap. With sat_bits at 0, an out-of-range value keeps only its low output-width bits.
- R7: In wrap mode with sat_bits = N > 0, an out-of-range value takes its N most significant output bits from the limit it crossed (maximum on the high side, minimum on the low side) and keeps its lower bits wrapped. An N of at least the output width gives full saturation.
- R8: Overflow code 1 clamps to the output maximum on the high side and to the output minimum on the low side.
- R9: Overflow code 2 sets any out-of-range value to zero.
- R10: Overflow code 3 clamps the high side to the maximum. In signed form it clamps the low side to -(2^(W_OUT-1)-1), not to -2^(W_OUT-1).
- R11: Overflow code 4, in signed form, sets the output sign bit to the sign of the rounded value. It keeps the wrapped low bits when the wrapped sign bit already agrees and inverts them when it does not. This code ignores sat_bits.
- R12: out_ovf is 1 exactly when the rounded value lies outside the output range, whatever overflow code is chosen.
- R13: A result shows on out_valid/out_data/out_ovf one clock after in_valid is high. When in_valid is low, out_valid drops and out_data and out_ovf hold their values. Reset clears all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_data | input | W_IN | Input sample, I_IN integer bits |
| q_mode | input | 3 | Quantization rule code (R2 to R5) |
| o_mode | input | 3 | Overflow rule code (R6 to R11) |
| sat_bits | input | NSW | Number of forced high bits in wrap mode |
| out_valid | output | 1 | Result valid |
| out_data | output | W_OUT | Result, I_OUT integer bits |
| out_ovf | output | 1 | Overflow rule changed the value |

## Verification
The bench uses the default parameters: a signed 18-bit input with 6 integer bits, converted to a signed 8-bit output with 4 integer bits. Eight fraction bits are dropped with this setup, so half-step ties, near-ties and exact values can all be reached. The input integer range is four times the output range, so every overflow rule is exercised on both sides. The output is narrow enough that every sat_bits value from 0 past the output width can be tried, and the low limit of 0x80 can be told apart from the symmetric limit of 0x81.

// File: rtl/fxq_pkg.sv
package fxq_pkg;

  typedef enum logic [2:0] {
    Q_TRN       = 3'd0,
    Q_RND_UP    = 3'd1,
    Q_RND_ZERO  = 3'd2,
    Q_RND_DOWN  = 3'd3,
    Q_RND_AWAY  = 3'd4,
    Q_RND_EVEN  = 3'd5,
    Q_TRN_ZERO  = 3'd6,
    Q_RSVD      = 3'd7
  } qmode_e;

  typedef enum logic [2:0] {
    OV_WRAP     = 3'd0,
    OV_SAT      = 3'd1,
    OV_SAT_ZERO = 3'd2,
    OV_SAT_SYM  = 3'd3,
    OV_WRAP_SM  = 3'd4,
    OV_RSVD5    = 3'd5,
    OV_RSVD6    = 3'd6,
    OV_RSVD7    = 3'd7
  } omode_e;

endpackage

// File: rtl/fxq_align_round.sv
module fxq_align_round
  import fxq_pkg::*;
#(
  parameter int W_IN   = 18,
  parameter int I_IN   = 6,
  parameter int W_OUT  = 8,
  parameter int I_OUT  = 4,
  parameter bit SIGNED = 1'b1,
  parameter int WX     = 20
) (
  input  logic [W_IN-1:0]      in_data,
  input  qmode_e               qm,
  output logic signed [WX-1:0] y
);

  localparam int F_IN  = W_IN - I_IN;
  localparam int F_OUT = W_OUT - I_OUT;
  localparam int LSH   = (F_OUT > F_IN) ? (F_OUT - F_IN) : 0;
  localparam int RSH   = (F_IN > F_OUT) ? (F_IN - F_OUT) : 0;

  logic               fill;
  logic signed [WX-1:0] ext;
  logic signed [WX-1:0] sh;
  logic signed [WX-1:0] q;
  logic               half;
  logic               rest;
  logic               neg;
  logic               inc;

  always_comb begin
    fill = SIGNED ? in_data[W_IN-1] : 1'b0;
    ext  = {{(WX-W_IN){fill}}, in_data};
    sh   = ext <<< LSH;
    q    = sh >>> RSH;
    neg  = sh[WX-1];
  end

  generate
    if (RSH > 1) begin : g_drop_multi
      always_comb begin
        half = sh[RSH-1];
        rest = |sh[RSH-2:0];
      end
    end else if (RSH == 1) begin : g_drop_one
      always_comb begin
        half = sh[0];
        rest = 1'b0;
      end
    end else begin : g_drop_none
      always_comb begin
        half = 1'b0;
        rest = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    unique case (qm)
      Q_RND_UP:   inc = half;
      Q_RND_ZERO: inc = half & (rest | neg);
      Q_RND_DOWN: inc = half & rest;
      Q_RND_AWAY: inc = half & (rest | ~neg);
      Q_RND_EVEN: inc = half & (rest | q[0]);
      Q_TRN_ZERO: inc = neg & (half | rest);
      default:    inc = 1'b0;
    endcase
    y = q + {{(WX-1){1'b0}}, inc};
  end

endmodule

// File: rtl/fxq_ovf.sv
module fxq_ovf
  import fxq_pkg::*;
#(
  parameter int W_OUT  = 8,
  parameter bit SIGNED = 1'b1,
  parameter int WX     = 20,
  parameter int NSW    = 4
) (
  input  logic signed [WX-1:0] y,
  input  omode_e               om,
  input  logic [NSW-1:0]       nsat,
  output logic [W_OUT-1:0]     res,
  output logic                 ovf
);

  localparam int WC = (WX > W_OUT + 1) ? WX : (W_OUT + 1);
  localparam logic signed [WC-1:0] ONE  = WC'(1);
  localparam logic signed [WC-1:0] MAXV = SIGNED ? ((ONE <<< (W_OUT-1)) - ONE)
                                                 : ((ONE <<< W_OUT) - ONE);
  localparam logic signed [WC-1:0] MINV = SIGNED ? -(ONE <<< (W_OUT-1)) : '0;
  localparam logic signed [WC-1:0] SYMN = SIGNED ? -MAXV : '0;

  logic signed [WC-1:0] yc;
  logic                 hi;
  logic                 lo;
  logic [W_OUT-1:0]     wrapped;
  logic [W_OUT-1:0]     lim;
  logic [W_OUT-1:0]     topmask;
  logic [W_OUT-1:0]     smres;

  always_comb begin
    yc      = {{(WC-WX){y[WX-1]}}, y};
    hi      = yc > MAXV;
    lo      = yc < MINV;
    ovf     = hi | lo;
    wrapped = yc[W_OUT-1:0];
    lim     = hi ? MAXV[W_OUT-1:0] : MINV[W_OUT-1:0];
    for (int i = 0; i < W_OUT; i++) begin
      topmask[i] = (i >= (W_OUT - int'(nsat)));
    end
  end

  generate
    if (SIGNED) begin : g_sm_signed
      logic sgn;
      always_comb begin
        sgn   = yc[WC-1];
        smres = (wrapped[W_OUT-1] == sgn) ? {sgn, wrapped[W_OUT-2:0]}
                                          : {sgn, ~wrapped[W_OUT-2:0]};
      end
    end else begin : g_sm_unsigned
      always_comb smres = wrapped;
    end
  endgenerate

  always_comb begin
    res = wrapped;
    if (ovf) begin
      unique case (om)
        OV_SAT:      res = lim;
        OV_SAT_ZERO: res = '0;
        OV_SAT_SYM:  res = hi ? MAXV[W_OUT-1:0] : SYMN[W_OUT-1:0];
        OV_WRAP_SM:  res = smres;
        default:     res = (wrapped & ~topmask) | (lim & topmask);
      endcase
    end
  end

endmodule

// File: rtl/fxq_requant.sv
module fxq_requant
  import fxq_pkg::*;
#(
  parameter int W_IN   = 18,
  parameter int I_IN   = 6,
  parameter int W_OUT  = 8,
  parameter int I_OUT  = 4,
  parameter bit SIGNED = 1'b1,
  parameter int NSW    = $clog2(W_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W_IN-1:0]  in_data,
  input  logic [2:0]       q_mode,
  input  logic [2:0]       o_mode,
  input  logic [NSW-1:0]   sat_bits,
  output logic             out_valid,
  output logic [W_OUT-1:0] out_data,
  output logic             out_ovf
);

  localparam int F_IN  = W_IN - I_IN;
  localparam int F_OUT = W_OUT - I_OUT;
  localparam int LSH   = (F_OUT > F_IN) ? (F_OUT - F_IN) : 0;
  localparam int WX    = W_IN + LSH + 2;
  localparam logic [W_OUT-1:0] OUT_MAX = SIGNED ? {1'b0, {(W_OUT-1){1'b1}}} : {W_OUT{1'b1}};
  localparam logic [W_OUT-1:0] OUT_MIN = SIGNED ? {1'b1, {(W_OUT-1){1'b0}}} : '0;

  logic signed [WX-1:0] y_q;
  logic [W_OUT-1:0]     res_c;
  logic                 ovf_c;
  logic                 valid_nxt;
  logic [W_OUT-1:0]     data_nxt;
  logic                 ovf_nxt;

  fxq_align_round #(
    .W_IN(W_IN), .I_IN(I_IN), .W_OUT(W_OUT), .I_OUT(I_OUT),
    .SIGNED(SIGNED), .WX(WX)
  ) u_round (
    .in_data (in_data),
    .qm      (qmode_e'(q_mode)),
    .y       (y_q)
  );

  fxq_ovf #(
    .W_OUT(W_OUT), .SIGNED(SIGNED), .WX(WX), .NSW(NSW)
  ) u_ovf (
    .y    (y_q),
    .om   (omode_e'(o_mode)),
    .nsat (sat_bits),
    .res  (res_c),
    .ovf  (ovf_c)
  );

  always_comb begin
    valid_nxt = in_valid;
    data_nxt  = in_valid ? res_c : out_data;
    ovf_nxt   = in_valid ? ovf_c : out_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
      out_data  <= data_nxt;
      out_ovf   <= ovf_nxt;
    end
  end

  // R13: result appears one clock after a valid sample
  a_r13_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R13: outputs hold while no sample is offered
  a_r13_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_ovf)));

  // R8: saturation lands on one of the two range limits
  a_r8_sat_limits: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && o_mode == OV_SAT) |=> (!out_ovf || out_data == OUT_MAX || out_data == OUT_MIN));

  // R9: saturate-to-zero yields zero on overflow
  a_r9_sat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && o_mode == OV_SAT_ZERO) |=> (!out_ovf || out_data == '0));

  // R10: symmetric saturation never produces the most negative code
  a_r10_sym_no_min: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && o_mode == OV_SAT_SYM && SIGNED) |=> (!out_ovf || out_data != OUT_MIN));

  // R12: without overflow the registered result equals the low bits of the rounded value
  a_r12_no_flag_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ovf_c) |=> (!out_ovf && out_data == $past(y_q[W_OUT-1:0])));

endmodule

// File: tb/fxq_requant_tb_top.sv
`timescale 1ns/1ps
module fxq_requant_tb_top;

  localparam int W_IN  = 18;
  localparam int I_IN  = 6;
  localparam int W_OUT = 8;
  localparam int I_OUT = 4;
  localparam int NSW   = $clog2(W_OUT + 1);
  localparam int RS    = (W_IN - I_IN) - (W_OUT - I_OUT);
  localparam longint OMAX = (64'sd1 <<< (W_OUT-1)) - 1;
  localparam longint OMIN = -(64'sd1 <<< (W_OUT-1));

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [W_IN-1:0]  in_data;
  logic [2:0]       q_mode;
  logic [2:0]       o_mode;
  logic [NSW-1:0]   sat_bits;
  logic             out_valid;
  logic [W_OUT-1:0] out_data;
  logic             out_ovf;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  fxq_requant #(
    .W_IN(W_IN), .I_IN(I_IN), .W_OUT(W_OUT), .I_OUT(I_OUT), .SIGNED(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .q_mode(q_mode), .o_mode(o_mode), .sat_bits(sat_bits),
    .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // returns {overflow flag, output code}
  function automatic logic [W_OUT:0] model(longint x, int qm, int om, int n);
    longint q, r, y, wrapped, lim, m, mk, lsb;
    bit half, rest, neg, inc, hi, lo, sg, wb;
    longint res;
    mk   = (64'sd1 <<< W_OUT) - 1;
    q    = x >>> RS;
    r    = x - (q <<< RS);
    half = r >= (64'sd1 <<< (RS-1));
    rest = (r & ((64'sd1 <<< (RS-1)) - 1)) != 0;
    neg  = x < 0;
    lsb  = q & 1;
    case (qm)
      1: inc = half;
      2: inc = half && (rest || neg);
      3: inc = half && rest;
      4: inc = half && (rest || !neg);
      5: inc = half && (rest || lsb != 0);
      6: inc = neg && (r != 0);
      default: inc = 0;
    endcase
    y = q + (inc ? 1 : 0);
    hi = y > OMAX;
    lo = y < OMIN;
    wrapped = y & mk;
    lim = (hi ? OMAX : OMIN) & mk;
    res = wrapped;
    if (hi || lo) begin
      case (om)
        1: res = lim;
        2: res = 0;
        3: res = hi ? OMAX : ((-OMAX) & mk);
        4: begin
          sg = y < 0;
          wb = ((wrapped >> (W_OUT-1)) & 1) != 0;
          if (wb == sg) res = ({63'd0, sg} << (W_OUT-1)) | (wrapped & (mk >> 1));
          else          res = ({63'd0, sg} << (W_OUT-1)) | ((~wrapped) & (mk >> 1));
        end
        default: begin
          m = (n >= W_OUT) ? mk : ((((64'sd1 <<< n) - 1) <<< (W_OUT-n)) & mk);
          res = (wrapped & ~m) | (lim & m);
        end
      endcase
    end
    return {(hi || lo), res[W_OUT-1:0]};
  endfunction

  function automatic string tag(bit ov, int qm, int om, int n);
    if (ov) begin
      case (om)
        1: return "R8";
        2: return "R9";
        3: return "R10";
        4: return "R11";
        default: return (n > 0) ? "R7" : "R6";
      endcase
    end
    case (qm)
      0, 7: return "R2";
      5: return "R4";
      6: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string req, logic [W_OUT:0] got, logic [W_OUT:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got ovf=%0b data=%02h, expected ovf=%0b data=%02h",
               req, got[W_OUT], got[W_OUT-1:0], exp[W_OUT], exp[W_OUT-1:0]);
    end
  endtask

  // drive at a falling edge, compare one cycle later (after the register)
  task automatic run(longint x, int qm, int om, int n, string req);
    logic [W_OUT:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x[W_IN-1:0];
    q_mode   = qm[2:0];
    o_mode   = om[2:0];
    sat_bits = n[NSW-1:0];
    e = model(x, qm, om, n);
    @(negedge clk);
    check(req.len() ? req : tag(e[W_OUT], qm, om, n), {out_ovf, out_data}, e);
    check("R13", {8'd0, out_valid}, 9'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    q_mode = '0; o_mode = '0; sat_bits = '0;
    repeat (3) @(negedge clk);
    check("R13", {out_valid, out_ovf, out_data[6:0]}, 9'd0);
    check("R13", {out_ovf, out_data}, 9'd0);
    rst_n = 1'b1;

    // exact hand-computed values
    run(640, 5, 0, 0, "R4");                 // 2.5 steps -> 2
    check("R4", {out_ovf, out_data}, 9'h002);
    run(-131072, 0, 3, 0, "R10");            // deep negative -> -127
    check("R10", {out_ovf, out_data}, 9'h181);
    run(-131072, 0, 1, 0, "R8");
    check("R8", {out_ovf, out_data}, 9'h180);
    run(512, 0, 0, 0, "R1");                  // exactly 2 steps
    check("R1", {out_ovf, out_data}, 9'h002);
    run(-384, 6, 0, 0, "R5");                 // -1.5 -> -1
    check("R5", {out_ovf, out_data}, 9'h0FF);

    // tie cases for each quantization code
    for (int qm = 0; qm < 8; qm++) begin
      run(384, qm, 0, 0, "");
      run(-384, qm, 0, 0, "");
      run(640, qm, 0, 0, "");
      run(-640, qm, 0, 0, "");
      run(385, qm, 0, 0, "");
      run(-383, qm, 0, 0, "");
    end
    // rounding carries into overflow: 127.5 steps
    run(32640, 1, 1, 0, "R12");
    run(32640, 0, 1, 0, "R12");
    // overflow codes on both sides, varied sat_bits
    for (int om = 0; om < 8; om++) begin
      for (int n = 0; n < 10; n += 3) begin
        run(40000, 0, om, n, "");
        run(-40000, 0, om, n, "");
        run(131071, 4, om, n, "");
        run(-33000, 2, om, n, "");
      end
    end

    // idle cycle: outputs hold, valid drops
    begin
      logic [W_OUT:0] prev;
      prev = {out_ovf, out_data};
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 18'h0A5A5;
      o_mode   = 3'd2;
      @(negedge clk);
      check("R13", {8'd0, out_valid}, 9'd0);
      check("R13", {out_ovf, out_data}, prev);
    end

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      longint x;
      int sel;
      sel = int'($urandom % 4);
      if (sel == 0) x = (longint'($urandom % 64) - 32) * 128;
      else if (sel == 1) x = longint'($urandom % 65536) - 32768;
      else x = longint'($urandom % 262144) - 131072;
      run(x, int'($urandom % 8), int'($urandom % 8), int'($urandom % 10), "");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule